// File: doc/BRIEF.md
# Set-Associative Joint TLB Command Unit

This block holds the main translation table of a memory management unit and lets software manage it through four values: a staging word for the virtual side of an entry, a staging word for the physical side, an index word, and a command. The table has 128 sets and 2 or 4 ways. Software loads the staging words through a plain register write port. It then issues one command at a time: probe, get-index, write, write-without-micro-invalidate or read. The unit runs each command against the entry store and leaves its result in the index word or in the staging words.

The command port is valid/ready. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` then stays low while the command runs. The sender must hold `cmd_valid` and `cmd_op` steady until the command is taken. `utlb_inv` is a one-cycle pulse that tells the downstream micro-TLBs to drop their contents. It fires only for the plain write command.

Staging-word layout (virtual side): bits [31:13] virtual page, bit 10 valid, bit 9 global, bits [7:0] address-space ID. The set is selected by bits [19:13]. The physical-side word is stored and returned unchanged. Software places the frame in bits [31:13], kernel read/write/execute in bits [5:3] and user read/write/execute in bits [2:0].

Top module: `jtlb_cmd_unit`

## Requirements
- R1: After reset the three staging/index words read zero, every entry is invalid, `busy` and `utlb_inv` are low and `cmd_ready` is high.
- R2: A command is accepted on an edge with `cmd_valid` and `cmd_ready` both high. `busy` is then high, and `cmd_ready` low, for exactly two cycles. The command's results are visible in the cycle where `cmd_ready` returns high.
- R3: Probe (op 1) with exactly one matching way in the addressed set loads the index word with the linear index set*WAYS+way, upper bits zero.
- R4: Probe with no matching way loads the index word with 32'h8000_0000 (lookup-error flag in bit 31).
- R5: Probe with two or more matching ways loads the index word with the duplicate code 32'hC000_0000.
- R6: A stored entry matches the probe key when its valid bit 10 is set, its bits [31:13] equal the key's, and either its global bit 9 is set or its bits [7:0] equal the key's.
- R7: Get-index (op 2) writes the linear index of the lowest-numbered invalid way of the set selected by the virtual-side word. If every way is valid, it uses that set's round-robin pointer instead. The pointer starts at way 0 and advances by one (wrapping) only on each such fallback.
- R8: Write (op 3) and write-without-micro-invalidate (op 4) copy both staging words into the entry named by the low index bits. Writing zeros makes the entry invalid.
- R9: Read (op 5) loads both staging words from the entry named by the low index bits.
- R10: `utlb_inv` pulses high for one cycle, in the cycle the command completes, after op 3 only. It stays low after op 4 and every other op.
- R11: Register writes select the word by `reg_sel`: 0 virtual side, 1 physical side, 2 index. Select 3, and any register write while `busy` is high, change nothing.
- R12: Ops 0, 6 and 7 complete with the normal two-cycle timing and change no staging word, index word or entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 virtual side, 1 physical side, 2 index |
| reg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | Command valid |
| cmd_op | input | 3 | Command code: 1 probe, 2 get-index, 3 write, 4 write no micro-invalidate, 5 read |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| busy | output | 1 | Command in progress |
| pd0_q | output | 32 | Virtual-side staging word |
| pd1_q | output | 32 | Physical-side staging word |
| index_q | output | 32 | Index word, including the error codes |
| utlb_inv | output | 1 | One-cycle micro-TLB invalidate request |

## Verification
A corrupt entry or a wrong match stays hidden until software probes the set that holds it. At that probe, the index word shows a wrong linear index, a miss, or a duplicate code in the same cycle that `cmd_ready` returns. A wrong round-robin pointer shows only on a get-index into a full set, so the tests fill a set and then cycle through it. Timing faults in the sequencer appear at once as a wrong busy length or a misplaced `utlb_inv` pulse.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int VALID_BIT  = 10;
  localparam int GLOBAL_BIT = 9;
  localparam int ASID_W     = 8;

  localparam logic [WORD_W-1:0] IDX_MISS = 32'h8000_0000;
  localparam logic [WORD_W-1:0] IDX_DUP  = 32'hC000_0000;

  localparam logic [1:0] SEL_VSIDE = 2'd0;
  localparam logic [1:0] SEL_PSIDE = 2'd1;
  localparam logic [1:0] SEL_INDEX = 2'd2;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROBE   = 3'd1,
    OP_GETIDX  = 3'd2,
    OP_WRITE   = 3'd3,
    OP_WRITENI = 3'd4,
    OP_READ    = 3'd5
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_DO} state_e;

  function automatic logic entry_match(logic [WORD_W-1:0] stored, logic [WORD_W-1:0] key);
    return stored[VALID_BIT]
        && (stored[WORD_W-1:PAGE_SHIFT] == key[WORD_W-1:PAGE_SHIFT])
        && (stored[GLOBAL_BIT] || (stored[ASID_W-1:0] == key[ASID_W-1:0]));
  endfunction
endpackage

// File: rtl/jtlb_set_match.sv
module jtlb_set_match
  import jtlb_pkg::*;
#(
  parameter int NUM_WAYS = 2
) (
  input  logic [NUM_WAYS-1:0][WORD_W-1:0] ways_pd0,
  input  logic [WORD_W-1:0]               key,
  output logic [NUM_WAYS-1:0]             hit,
  output logic [NUM_WAYS-1:0]             free_w
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    assign hit[g]    = entry_match(ways_pd0[g], key);
    assign free_w[g] = !ways_pd0[g][VALID_BIT];
  end
endmodule

// File: rtl/jtlb_way_pick.sv
module jtlb_way_pick #(
  parameter  int N = 2,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/jtlb_victim.sv
module jtlb_victim #(
  parameter  int NUM_SETS = 128,
  parameter  int NUM_WAYS = 2,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set,
  input  logic             adv,
  output logic [WAY_W-1:0] way
);
  logic [WAY_W-1:0] ptr [NUM_SETS];

  assign way = ptr[set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ptr[s] <= '0;
    end else if (adv) begin
      ptr[set] <= ptr[set] + WAY_W'(1);
    end
  end
endmodule

// File: rtl/jtlb_cmd_unit.sv
module jtlb_cmd_unit
  import jtlb_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  output logic        cmd_ready,
  output logic        busy,
  output logic [31:0] pd0_q,
  output logic [31:0] pd1_q,
  output logic [31:0] index_q,
  output logic        utlb_inv
);
  localparam int SET_W   = $clog2(NUM_SETS);
  localparam int WAY_W   = $clog2(NUM_WAYS);
  localparam int ENTRIES = NUM_SETS * NUM_WAYS;
  localparam int IDX_W   = $clog2(ENTRIES);

  state_e state;
  op_e    op_q;
  logic [SET_W-1:0] set_q;
  logic [NUM_WAYS-1:0][WORD_W-1:0] snap_pd0;
  logic [WORD_W-1:0] rd_pd0, rd_pd1;
  logic [WORD_W-1:0] ram_pd0 [ENTRIES];
  logic [WORD_W-1:0] ram_pd1 [ENTRIES];

  logic [NUM_WAYS-1:0] hit, free_w;
  logic hit_any, free_any;
  logic [WAY_W-1:0] hit_way, free_way, vict_way;
  logic [SET_W-1:0] look_set;
  logic [IDX_W-1:0] ent;
  logic vict_adv;

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = (state == ST_IDLE);
  assign ent       = index_q[IDX_W-1:0];
  assign look_set  = (op_q == OP_PROBE || op_q == OP_GETIDX) ?
                     pd0_q[PAGE_SHIFT +: SET_W] : ent[WAY_W +: SET_W];
  assign vict_adv  = (state == ST_DO) && (op_q == OP_GETIDX) && !free_any;

  jtlb_set_match #(.NUM_WAYS(NUM_WAYS)) u_match (
    .ways_pd0(snap_pd0), .key(pd0_q), .hit(hit), .free_w(free_w)
  );

  jtlb_way_pick #(.N(NUM_WAYS)) u_hit_pick (
    .vec(hit), .any(hit_any), .idx(hit_way)
  );

  jtlb_way_pick #(.N(NUM_WAYS)) u_free_pick (
    .vec(free_w), .any(free_any), .idx(free_way)
  );

  jtlb_victim #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .set(set_q), .adv(vict_adv), .way(vict_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_NONE;
      set_q    <= '0;
      snap_pd0 <= '0;
      rd_pd0   <= '0;
      rd_pd1   <= '0;
      pd0_q    <= '0;
      pd1_q    <= '0;
      index_q  <= '0;
      utlb_inv <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        ram_pd0[i] <= '0;
        ram_pd1[i] <= '0;
      end
    end else begin
      utlb_inv <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reg_wr_en) begin
            case (reg_sel)
              SEL_VSIDE: pd0_q   <= reg_wdata;
              SEL_PSIDE: pd1_q   <= reg_wdata;
              SEL_INDEX: index_q <= reg_wdata;
              default: ;
            endcase
          end
          if (cmd_valid) begin
            op_q  <= op_e'(cmd_op);
            state <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          set_q <= look_set;
          for (int w = 0; w < NUM_WAYS; w++) begin
            snap_pd0[w] <= ram_pd0[{look_set, WAY_W'(w)}];
          end
          rd_pd0 <= ram_pd0[ent];
          rd_pd1 <= ram_pd1[ent];
          state  <= ST_DO;
        end
        ST_DO: begin
          case (op_q)
            OP_PROBE: begin
              if (!hit_any)                  index_q <= IDX_MISS;
              else if ($countones(hit) > 1)  index_q <= IDX_DUP;
              else                           index_q <= WORD_W'({set_q, hit_way});
            end
            OP_GETIDX: index_q <= WORD_W'({set_q, free_any ? free_way : vict_way});
            OP_WRITE, OP_WRITENI: begin
              ram_pd0[ent] <= pd0_q;
              ram_pd1[ent] <= pd1_q;
              utlb_inv     <= (op_q == OP_WRITE);
            end
            OP_READ: begin
              pd0_q <= rd_pd0;
              pd1_q <= rd_pd1;
            end
            default: ;
          endcase
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jtlb_checker.sv
module jtlb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        busy,
  input logic        utlb_inv,
  input logic [31:0] pd1_q
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy); // R2
  AST_BUSY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |=> busy); // R2
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy); // R2
  AST_INV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |=> !utlb_inv); // R10
  AST_INV_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |-> (!busy && $past(busy))); // R10
  AST_PSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pd1_q)); // R11
endmodule

bind jtlb_cmd_unit jtlb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .utlb_inv(utlb_inv), .pd1_q(pd1_q)
);

// File: tb/jtlb_cmd_unit_test.sv
`timescale 1ns/1ps
module jtlb_cmd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_ready, busy, utlb_inv;
  logic [31:0] pd0_q, pd1_q, index_q;

  int checks = 0;
  int errors = 0;
  int busy_cycles;
  logic ready_low_seen;
  logic last_inv;

  localparam logic [31:0] MISS = 32'h8000_0000;
  localparam logic [31:0] DUP  = 32'hC000_0000;

  always #2.5 clk = ~clk;

  jtlb_cmd_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .busy(busy), .pd0_q(pd0_q), .pd1_q(pd1_q),
    .index_q(index_q), .utlb_inv(utlb_inv)
  );

  function automatic logic [31:0] mk(logic [18:0] vpn, logic glob, logic [7:0] asid);
    return {vpn, 2'b00, 1'b1, glob, 1'b0, asid};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic cmd(logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_cycles = 0;
    ready_low_seen = !cmd_ready;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
    last_inv = utlb_inv;
  endtask

  task automatic t_reset();
    chk("R1 vside", pd0_q, 0);
    chk("R1 pside", pd1_q, 0);
    chk("R1 index", index_q, 0);
    chk("R1 busy/ready/inv", {29'd0, busy, cmd_ready, utlb_inv}, 32'd2);
    wr(2'd0, mk(19'h00085, 1'b0, 8'h12));
    cmd(3'd1);
    chk("R1 R4 probe empty table", index_q, MISS);
  endtask

  task automatic t_handshake();
    cmd(3'd1);
    chk("R2 busy length", busy_cycles, 2);
    chk("R2 ready low while busy", {31'd0, ready_low_seen}, 1);
    chk("R2 ready back", {31'd0, cmd_ready}, 1);
  endtask

  task automatic t_fill_set();
    wr(2'd0, mk(19'h00085, 1'b0, 8'h12));
    cmd(3'd2);
    chk("R7 first free way", index_q, 10);
    wr(2'd1, 32'hAAAA_A03F);
    cmd(3'd3);
    chk("R10 pulse after write", {31'd0, last_inv}, 1);
    wr(2'd0, mk(19'h00105, 1'b0, 8'h12));
    cmd(3'd2);
    chk("R7 next free way", index_q, 11);
    wr(2'd1, 32'h5555_4007);
    cmd(3'd4);
    chk("R10 no pulse after write-ni", {31'd0, last_inv}, 0);
    wr(2'd0, mk(19'h00085, 1'b0, 8'h12));
    cmd(3'd1);
    chk("R3 probe way 0", index_q, 10);
    wr(2'd0, mk(19'h00105, 1'b0, 8'h12));
    cmd(3'd1);
    chk("R3 probe way 1", index_q, 11);
  endtask

  task automatic t_read();
    wr(2'd2, 32'd10);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    cmd(3'd5);
    chk("R9 read vside", pd0_q, mk(19'h00085, 1'b0, 8'h12));
    chk("R9 read pside", pd1_q, 32'hAAAA_A03F);
    chk("R10 no pulse after read", {31'd0, last_inv}, 0);
  endtask

  task automatic t_victim();
    wr(2'd0, mk(19'h00185, 1'b0, 8'h12));
    cmd(3'd2);
    chk("R7 victim first", index_q, 10);
    cmd(3'd2);
    chk("R7 victim second", index_q, 11);
    cmd(3'd2);
    chk("R7 victim wraps", index_q, 10);
  endtask

  task automatic t_asid();
    wr(2'd0, mk(19'h00085, 1'b0, 8'h34));
    cmd(3'd1);
    chk("R6 asid mismatch misses", index_q, MISS);
    wr(2'd0, mk(19'h00009, 1'b1, 8'h55));
    cmd(3'd2);
    chk("R7 free way set 9", index_q, 18);
    wr(2'd1, 32'h0000_0038);
    cmd(3'd3);
    wr(2'd0, mk(19'h00009, 1'b0, 8'h77));
    cmd(3'd1);
    chk("R6 global ignores asid", index_q, 18);
    wr(2'd0, mk(19'h00089, 1'b0, 8'h55));
    cmd(3'd1);
    chk("R6 page mismatch misses", index_q, MISS);
  endtask

  task automatic t_dup();
    wr(2'd0, mk(19'h00007, 1'b0, 8'h01));
    wr(2'd1, 32'h1);
    wr(2'd2, 32'd14);
    cmd(3'd3);
    wr(2'd2, 32'd15);
    cmd(3'd4);
    cmd(3'd1);
    chk("R5 duplicate code", index_q, DUP);
    wr(2'd2, 32'd14);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    cmd(3'd3);
    wr(2'd0, mk(19'h00007, 1'b0, 8'h01));
    cmd(3'd1);
    chk("R8 erased way no longer matches", index_q, 15);
  endtask

  task automatic t_busy_ignore();
    wr(2'd1, 32'h0000_1234);
    wr(2'd3, 32'hDEAD_BEEF);
    chk("R11 select 3 leaves vside", pd0_q, mk(19'h00007, 1'b0, 8'h01));
    chk("R11 select 3 leaves pside", pd1_q, 32'h0000_1234);
    chk("R11 select 3 leaves index", index_q, 15);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr_en = 1'b0;
    while (busy) @(negedge clk);
    chk("R11 write while busy dropped", pd1_q, 32'h0000_1234);
  endtask

  task automatic t_unknown();
    wr(2'd2, 32'd18);
    cmd(3'd7);
    chk("R12 op 7 timing", busy_cycles, 2);
    chk("R12 op 7 index kept", index_q, 18);
    chk("R12 op 7 pside kept", pd1_q, 32'h0000_1234);
    chk("R12 op 7 no pulse", {31'd0, last_inv}, 0);
    cmd(3'd6);
    cmd(3'd0);
    wr(2'd0, mk(19'h00009, 1'b1, 8'h00));
    cmd(3'd1);
    chk("R12 entries unchanged", index_q, 18);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_fill_set();
    t_read();
    t_victim();
    t_asid();
    t_dup();
    t_busy_ignore();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule